// File: doc/BRIEF.md
# Fractional Baud Tick Generator

This block turns the peripheral clock into the clock-enable tick that drives a UART's 16x oversampling logic. The tick rate comes from a 16-bit integer divisor, given as a high byte and a low byte, stretched by a rational factor (1 + add/mul). The two 4-bit fields add and mul share one configuration byte. Because of the stretch, the average tick period can be a fraction of a clock cycle away from a whole number. Each single period stays within one cycle of that average.

The stretch uses an accumulator. Every enabled cycle it grows by mul. When it reaches the threshold D·(mul+add), where D is the combined divisor, the threshold is taken off and a tick goes out. The residue is kept, so the rate does not drift over time. New settings are captured while the enable is low or at the cycle where a period closes, so a change never cuts a period short. A separate output flags settings that would give an undefined rate.

Top module: `frac_baud_tick`

## Requirements
- R1: While reset is asserted, and during the synchronizer cycles after its release, `tick` is 0. With the reset-default inputs (divisor 1, add 0, mul 1), `cfg_err` is 0.
- R2: When add (`frac_word[3:0]`) is 0, every tick period is exactly D = 256·`div_hi` + `div_lo` cycles.
- R3: Count from the cycle `en` rises, over mul·D·(mul+add) enabled cycles, where mul is `frac_word[7:4]`. Exactly mul² ticks are produced.
- R4: With add > 0, every tick period is either floor(D·(mul+add)/mul) or ceil(D·(mul+add)/mul) cycles.
- R5: When the shortest legal period is 2 cycles or more, `tick` is never high in two consecutive cycles.
- R6: While `en` is low, `tick` is 0 and the accumulator is cleared. The first tick after `en` rises comes ceil(D·(mul+add)/mul) cycles later, counting the first enabled edge as 1.
- R7: `cfg_err` is 1 whenever mul is 0, add is 15, or add ≥ mul.
- R8: `cfg_err` is 1 when add > 0, `div_hi` = 0 and `div_lo` < 3. With `div_hi` nonzero or add = 0, a small `div_lo` raises no error.
- R9: A combined divisor of 0 acts as 1. With add = 0 this gives one tick in every enabled cycle.
- R10: A divisor or fraction change made in the middle of a period does not alter that period. The new setting takes effect from the next period onward.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| div_hi | input | 8 | High byte of the integer divisor |
| div_lo | input | 8 | Low byte of the integer divisor |
| frac_word | input | 8 | Fraction settings: add in bits 3:0, mul in bits 7:4 |
| en | input | 1 | Run enable; low holds the tick low and clears the accumulator |
| tick | output | 1 | One-cycle 16x oversampling tick |
| cfg_err | output | 1 | Illegal fraction or divisor setting |

## Verification
Two events can land in the same cycle: the accumulator wrapping to close a period, and the capture of new settings. The bench changes the divisor in the middle of a period. It then checks that the period in progress keeps its old length and that the next period already has the new length. The same clash at enable time is provoked by dropping `en` mid-period and raising it again. The first tick after that must arrive after a full fresh period.

// File: rtl/fbt_pkg.sv
package fbt_pkg;
  localparam int BYTE_W = 8;
  localparam int DIV_W  = 2 * BYTE_W;
  localparam int FRAC_W = 4;
  localparam int SUM_W  = FRAC_W + 1;
  localparam int THR_W  = DIV_W + SUM_W;
  localparam int MIN_LO = 3;
endpackage

// File: rtl/fbt_cfg_check.sv
module fbt_cfg_check
  import fbt_pkg::*;
#(
  parameter int BW = BYTE_W,
  parameter int FW = FRAC_W,
  parameter int LO_MIN = MIN_LO
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [BW-1:0] div_hi,
  input  logic [BW-1:0] div_lo,
  input  logic [FW-1:0] add_v,
  input  logic [FW-1:0] mul_v,
  output logic          err
);
  localparam logic [FW-1:0] FMAX = {FW{1'b1}};

  logic range_bad;
  logic small_div;

  always_comb begin
    range_bad = (mul_v == '0) || (add_v == FMAX) || (add_v >= mul_v);
    small_div = (add_v != '0) && (div_hi == '0) && (div_lo < BW'(LO_MIN));
    err       = range_bad | small_div;
  end

  // R7: zero multiplier always flags
  p_err_mul_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (mul_v == '0) |-> err);
  // R8: active fraction with a tiny divisor flags
  p_err_small_div_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (add_v != '0 && div_hi == '0 && div_lo < BW'(LO_MIN)) |-> err);
endmodule

// File: rtl/fbt_shadow.sv
module fbt_shadow
  import fbt_pkg::*;
#(
  parameter int BW  = BYTE_W,
  parameter int FW  = FRAC_W,
  parameter int DW  = 2 * BW,
  parameter int SW  = FW + 1,
  parameter int TW  = DW + SW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic          wrap,
  input  logic [BW-1:0] div_hi,
  input  logic [BW-1:0] div_lo,
  input  logic [FW-1:0] add_v,
  input  logic [FW-1:0] mul_v,
  output logic [FW-1:0] mul_q,
  output logic [TW-1:0] thr_q,
  output logic          cfg_change
);
  logic [DW-1:0] d_raw;
  logic [DW-1:0] d_eff;
  logic [SW-1:0] step_sum;
  logic [TW-1:0] thr_new;
  logic          load;
  logic [FW-1:0] mul_d;
  logic [TW-1:0] thr_d;

  always_comb begin
    d_raw      = {div_hi, div_lo};
    d_eff      = (d_raw == '0) ? DW'(1) : d_raw;
    step_sum   = SW'(mul_v) + SW'(add_v);
    thr_new    = TW'(d_eff) * TW'(step_sum);
    load       = !en || wrap;
    cfg_change = (thr_new != thr_q) || (mul_v != mul_q);
    mul_d      = load ? mul_v   : mul_q;
    thr_d      = load ? thr_new : thr_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mul_q <= FW'(1);
      thr_q <= TW'(1);
    end else if (load) begin
      mul_q <= mul_d;
      thr_q <= thr_d;
    end
  end

  // R10: settings held while a period is running
  p_hold_midperiod_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !wrap) |=> $stable(thr_q) && $stable(mul_q));
endmodule

// File: rtl/fbt_accum.sv
module fbt_accum
  import fbt_pkg::*;
#(
  parameter int FW = FRAC_W,
  parameter int TW = THR_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic [FW-1:0] mul_q,
  input  logic [TW-1:0] thr_q,
  input  logic          cfg_change,
  output logic          wrap,
  output logic          tick
);
  logic [TW-1:0] acc_q;
  logic [TW-1:0] acc_d;
  logic [TW:0]   acc_sum;
  logic [TW:0]   acc_rem;
  logic          acc_en;
  logic          tick_q;
  logic          tick_d;

  always_comb begin
    acc_sum = {1'b0, acc_q} + {{(TW + 1 - FW){1'b0}}, mul_q};
    acc_rem = acc_sum - {1'b0, thr_q};
    wrap    = en && (acc_sum >= {1'b0, thr_q});
    acc_en  = en || (acc_q != '0);
    if (!en) begin
      acc_d = '0;
    end else if (wrap) begin
      acc_d = cfg_change ? '0 : acc_rem[TW-1:0];
    end else begin
      acc_d = acc_sum[TW-1:0];
    end
    tick_d = wrap;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q <= '0;
    end else if (acc_en) begin
      acc_q <= acc_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tick_q <= 1'b0;
    end else begin
      tick_q <= tick_d;
    end
  end

  assign tick = tick_q;

  // R6: no tick after a disabled cycle
  p_tick_low_off_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> !tick_q);
  // R6: accumulator emptied after a disabled cycle
  p_acc_cleared_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (acc_q == '0));
  // R4: residue stays below the period threshold
  p_acc_in_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (thr_q != '0) |-> (acc_q < thr_q));
endmodule

// File: rtl/frac_baud_tick.sv
module frac_baud_tick
  import fbt_pkg::*;
#(
  parameter int BW = BYTE_W,
  parameter int FW = FRAC_W
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [BW-1:0]   div_hi,
  input  logic [BW-1:0]   div_lo,
  input  logic [2*FW-1:0] frac_word,
  input  logic            en,
  output logic            tick,
  output logic            cfg_err
);
  localparam int DW = 2 * BW;
  localparam int SW = FW + 1;
  localparam int TW = DW + SW;

  logic [1:0]    rst_sync_q;
  logic          rst_sn;
  logic [FW-1:0] add_v;
  logic [FW-1:0] mul_v;
  logic [FW-1:0] mul_q;
  logic [TW-1:0] thr_q;
  logic          cfg_change;
  logic          wrap;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync_q <= 2'b00;
    end else begin
      rst_sync_q <= {rst_sync_q[0], 1'b1};
    end
  end
  assign rst_sn = rst_sync_q[1];

  assign add_v = frac_word[FW-1:0];
  assign mul_v = frac_word[2*FW-1:FW];

  fbt_cfg_check #(.BW(BW), .FW(FW), .LO_MIN(MIN_LO)) u_check (
    .clk    (clk),
    .rst_n  (rst_sn),
    .div_hi (div_hi),
    .div_lo (div_lo),
    .add_v  (add_v),
    .mul_v  (mul_v),
    .err    (cfg_err)
  );

  fbt_shadow #(.BW(BW), .FW(FW), .DW(DW), .SW(SW), .TW(TW)) u_shadow (
    .clk        (clk),
    .rst_n      (rst_sn),
    .en         (en),
    .wrap       (wrap),
    .div_hi     (div_hi),
    .div_lo     (div_lo),
    .add_v      (add_v),
    .mul_v      (mul_v),
    .mul_q      (mul_q),
    .thr_q      (thr_q),
    .cfg_change (cfg_change)
  );

  fbt_accum #(.FW(FW), .TW(TW)) u_accum (
    .clk        (clk),
    .rst_n      (rst_sn),
    .en         (en),
    .mul_q      (mul_q),
    .thr_q      (thr_q),
    .cfg_change (cfg_change),
    .wrap       (wrap),
    .tick       (tick)
  );

  // R1: tick held low until the synchronized reset is released
  p_quiet_in_reset_r1: assert property (@(posedge clk)
    !rst_sn |=> !tick);
endmodule

// File: tb/test_frac_baud_tick.sv
`timescale 1ns/1ps
module test_frac_baud_tick;
  logic       clk = 1'b0;
  logic       rst_n;
  logic [7:0] div_hi;
  logic [7:0] div_lo;
  logic [7:0] frac_word;
  logic       en;
  logic       tick;
  logic       cfg_err;

  int unsigned n_checks = 0;
  int unsigned n_errors = 0;
  bit          done = 1'b0;

  always #2 clk = ~clk;

  frac_baud_tick i_frac_baud_tick (
    .clk       (clk),
    .rst_n     (rst_n),
    .div_hi    (div_hi),
    .div_lo    (div_lo),
    .frac_word (frac_word),
    .en        (en),
    .tick      (tick),
    .cfg_err   (cfg_err)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    n_checks++;
    if (!ok) begin
      n_errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic longint d_of(input int hi, input int lo);
    longint d = hi * 256 + lo;
    return (d == 0) ? 1 : d;
  endfunction

  function automatic bit err_of(input int hi, input int lo, input int ad, input int mu);
    return (mu == 0) || (ad == 15) || (ad >= mu) || (ad != 0 && hi == 0 && lo < 3);
  endfunction

  task automatic set_cfg(input int hi, input int lo, input int ad, input int mu);
    div_hi    = 8'(hi);
    div_lo    = 8'(lo);
    frac_word = {4'(mu), 4'(ad)};
  endtask

  // Full-window run: interval checks, first-tick check and exact count
  task automatic run_cfg(input int hi, input int lo, input int ad, input int mu);
    longint t_thr, n_win, fl, ce, d;
    longint ticks, last, iv;
    bit prev, dbl;
    @(negedge clk);
    en = 1'b0;
    set_cfg(hi, lo, ad, mu);
    @(negedge clk);
    @(negedge clk);
    check(cfg_err == err_of(hi, lo, ad, mu), "R7", "cfg_err legal", cfg_err, err_of(hi, lo, ad, mu));
    d     = d_of(hi, lo);
    t_thr = d * (mu + ad);
    n_win = mu * t_thr;
    fl    = t_thr / mu;
    ce    = (t_thr + mu - 1) / mu;
    ticks = 0; last = 0; prev = 1'b0; dbl = 1'b0;
    en = 1'b1;
    for (longint c = 1; c <= n_win; c++) begin
      @(negedge clk);
      if (tick) begin
        ticks++;
        if (ticks == 1) begin
          check(c == ce, "R6", "first tick cycle", c, ce);
        end else begin
          iv = c - last;
          if (ad == 0) check(iv == d, "R2", "integer period", iv, d);
          else         check(iv == fl || iv == ce, "R4", "fractional period", iv, ce);
        end
        last = c;
        if (prev) dbl = 1'b1;
      end
      prev = tick;
    end
    check(ticks == mu * mu, "R3", "ticks in window", ticks, mu * mu);
    if (fl >= 2) check(!dbl, "R5", "back-to-back ticks", dbl, 0);
    en = 1'b0;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_errors++;
      $display("FAIL watchdog all-R: actual timeout expected completion");
      $display("  Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
    end
  end

  initial begin
    int c;
    int cnt;
    void'($urandom(32'd20161221));
    rst_n = 1'b0;
    en    = 1'b0;
    set_cfg(0, 1, 0, 1);
    repeat (3) @(negedge clk);
    check(tick == 1'b0, "R1", "tick in reset", tick, 0);
    check(cfg_err == 1'b0, "R1", "cfg_err default", cfg_err, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(tick == 1'b0, "R1", "tick after release", tick, 0);
    repeat (3) @(negedge clk);

    // R7 illegal fraction fields
    set_cfg(0, 10, 0, 0);  #1 check(cfg_err == 1'b1, "R7", "mul zero", cfg_err, 1);
    set_cfg(0, 10, 15, 15); #1 check(cfg_err == 1'b1, "R7", "add 15", cfg_err, 1);
    set_cfg(0, 10, 5, 5);  #1 check(cfg_err == 1'b1, "R7", "add eq mul", cfg_err, 1);
    set_cfg(0, 10, 6, 3);  #1 check(cfg_err == 1'b1, "R7", "add gt mul", cfg_err, 1);
    set_cfg(0, 10, 14, 15); #1 check(cfg_err == 1'b0, "R7", "largest legal", cfg_err, 0);
    // R8 small divisor with active fraction
    set_cfg(0, 2, 1, 2);   #1 check(cfg_err == 1'b1, "R8", "lo 2", cfg_err, 1);
    set_cfg(0, 0, 1, 2);   #1 check(cfg_err == 1'b1, "R8", "lo 0", cfg_err, 1);
    set_cfg(0, 3, 1, 2);   #1 check(cfg_err == 1'b0, "R8", "lo 3", cfg_err, 0);
    set_cfg(1, 0, 1, 2);   #1 check(cfg_err == 1'b0, "R8", "hi set", cfg_err, 0);
    set_cfg(0, 1, 0, 1);   #1 check(cfg_err == 1'b0, "R8", "integer lo 1", cfg_err, 0);

    // Directed windows
    run_cfg(0, 5, 0, 1);
    run_cfg(0, 3, 1, 2);
    run_cfg(1, 2, 0, 1);
    run_cfg(1, 0, 1, 2);
    run_cfg(0, 4, 14, 15);

    // R9: zero divisor acts as one
    run_cfg(0, 0, 0, 3);
    @(negedge clk);
    set_cfg(0, 0, 0, 1);
    en = 1'b1;
    cnt = 0;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (tick) cnt++;
    end
    check(cnt == 20, "R9", "ticks with zero divisor", cnt, 20);
    en = 1'b0;

    // R6: drop enable mid-period, then restart
    @(negedge clk);
    set_cfg(0, 7, 0, 1);
    @(negedge clk);
    en = 1'b1;
    repeat (4) @(negedge clk);
    en = 1'b0;
    cnt = 0;
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      if (tick) cnt++;
    end
    check(cnt == 0, "R6", "ticks while disabled", cnt, 0);
    en = 1'b1;
    c = 0;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      c++;
      if (tick) break;
    end
    check(c == 7, "R6", "first tick after restart", c, 7);
    en = 1'b0;

    // R10: change divisor mid-period
    @(negedge clk);
    set_cfg(0, 10, 0, 1);
    @(negedge clk);
    en = 1'b1;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      if (tick) break;
    end
    c = 0;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      c++;
    end
    set_cfg(0, 4, 0, 1);
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      c++;
      if (tick) break;
    end
    check(c == 10, "R10", "period in progress", c, 10);
    c = 0;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      c++;
      if (tick) break;
    end
    check(c == 4, "R10", "period after change", c, 4);
    en = 1'b0;

    // Constrained random legal settings
    for (int k = 0; k < 6; k++) begin
      int mu, ad, lo;
      mu = 1 + int'($urandom % 15);
      ad = int'($urandom % mu);
      lo = (ad > 0) ? 3 + int'($urandom % 18) : 1 + int'($urandom % 20);
      run_cfg(0, lo, ad, mu);
    end

    done = 1'b1;
    $display("  Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end
endmodule